// File: doc/BRIEF.md
# Neighbour-Linked Lookup RAM Ring

This block holds one private lookup RAM for each of sixteen processor cores. Each RAM is true dual-port. The owning core drives the first port. The second port belongs to the next higher-numbered core, and the last core links back to core 0. Every core therefore has a single-cycle data path to its lower neighbour's RAM. Its upper neighbour can reach its own RAM in the same way. Neither path goes through the shared hub.

A core makes an access by raising its request enable. A write strobe chooses between read and write, and a neighbour-select bit chooses between its own RAM and the RAM below it. Each core also has a one-bit share register that allows or blocks neighbour access to its own RAM. Read data is registered, so a read made at one clock edge shows its data on the outputs after that edge. A producer can write a word and a consumer can pick it up on the next cycle. A full write, read and poll loop stays within a handful of clocks.

Top module: `nbr_lut_ring`

## Requirements
- R1: While reset is asserted, and after it until a core's first read, every `rsp_rdata` lane is zero, and every share register is 0 (neighbour access blocked).
- R2: A read of a core's own RAM (`req_en`=1, `req_we`=0, `req_nbr`=0) presents the stored word on that core's `rsp_rdata` lane right after the clock edge that samples the request. A word written at one edge can be read back at the next edge.
- R3: With `req_nbr`=1, core c reaches the RAM owned by core c-1. Writes it makes there can be read by core c-1 on its own port, and writes made by core c-1 can be read by core c.
- R4: The ring wraps. Core 0's neighbour port reaches the RAM of core NUM_COGS-1.
- R5: If the owner port and the neighbour port both write the same address of one RAM in the same cycle, the owner's data is kept.
- R6: If one port reads an address while the other port writes it in the same cycle, the read returns the word stored before that write.
- R7: While a RAM owner's share bit is 0, neighbour writes to that RAM are dropped and neighbour reads of it return zero.
- R8: A core's `rsp_rdata` lane holds its value through idle cycles and through write accesses.
- R9: When `ctl_we[c]` is 1 at an edge, share bit c loads `ctl_val[c]`. The new value governs neighbour accesses from the following cycle on, and the cycle of the load still uses the old value.
- R10: All cores access their ports concurrently and independently, with no stall and no cycle lost to any combination of requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | NUM_COGS | Per-core load strobe for the share bit |
| ctl_val | input | NUM_COGS | Per-core value loaded into the share bit |
| req_en | input | NUM_COGS | Per-core access request |
| req_we | input | NUM_COGS | Per-core write strobe (1 write, 0 read) |
| req_nbr | input | NUM_COGS | Per-core target (0 own RAM, 1 lower neighbour's RAM) |
| req_addr | input | NUM_COGS*ADDR_W | Per-core word address, core c in bits [c*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_COGS*DATA_W | Per-core write data, core c in bits [c*DATA_W +: DATA_W] |
| rsp_rdata | output | NUM_COGS*DATA_W | Per-core registered read data, core c in bits [c*DATA_W +: DATA_W] |

## Verification
The bench aims at same-address collisions on one RAM. If the priority were reversed, the owner would read back its neighbour's word. If a port read its partner's new data in the collision cycle, the read-before-write check would see the fresh value one cycle early. Wrap-around between the last core and core 0 gets its own test, because a ring built as a chain would leave core 0 reading zeros. The share bit is changed in the same cycle as a neighbour access. A design that applied it at once, or that blocked only reads, would return the wrong word or let a blocked write through.

// File: rtl/nlr_pkg.sv
package nlr_pkg;

   // index of the core whose RAM a core reaches through its neighbour port
   function automatic int lower_of(input int c, input int n);
      return (c == 0) ? n - 1 : c - 1;
   endfunction

   // index of the core that drives the second port of a core's RAM
   function automatic int upper_of(input int c, input int n);
      return (c == n - 1) ? 0 : c + 1;
   endfunction

endpackage

// File: rtl/nlr_ctl.sv
module nlr_ctl #(
   parameter int NUM_COGS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_COGS-1:0] ctl_we,
   input  logic [NUM_COGS-1:0] ctl_val,
   output logic [NUM_COGS-1:0] share_q
);

   for (genvar i = 0; i < NUM_COGS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        share_q[i] <= 1'b0;
         else if (ctl_we[i]) share_q[i] <= ctl_val[i];
      end

      // R9: share bit only moves on a load strobe
      a_r9_share_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(ctl_we[i]) |-> $stable(share_q[i]));
   end

endmodule

// File: rtl/nlr_dpram.sv
module nlr_dpram #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_en,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   input  logic              b_allow,
   output logic [DATA_W-1:0] b_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic a_wr, b_wr, b_rd, a_rd, clash;

   assign a_wr  = a_en & a_we;
   assign a_rd  = a_en & ~a_we;
   assign b_rd  = b_en & ~b_we;
   assign clash = a_wr & (a_addr == b_addr);
   assign b_wr  = b_en & b_we & b_allow & ~clash;

   always_ff @(posedge clk) begin
      if (a_wr) mem[a_addr] <= a_wdata;
      if (b_wr) mem[b_addr] <= b_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    a_rdata <= '0;
      else if (a_rd) a_rdata <= mem[a_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_rdata <= '0;
      else if (b_rd) b_rdata <= b_allow ? mem[b_addr] : '0;
   end

   // R7: blocked neighbour read yields zero
   a_r7_blocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(b_en && !b_we && !b_allow) |-> (b_rdata == '0));

   // R2: owner write followed by owner read of the same word
   a_r2_write_read: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(a_en && a_we, 2) && $past(a_en && !a_we) &&
       ($past(a_addr) == $past(a_addr, 2))) |-> (a_rdata == $past(a_wdata, 2)));

   // R5: owner data survives a same-address collision
   a_r5_owner_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(a_en && a_we && b_en && b_we && b_allow && (a_addr == b_addr), 2) &&
       $past(b_en && !b_we && b_allow) && ($past(b_addr) == $past(a_addr, 2)) &&
       !$past(a_en && a_we && (a_addr == b_addr)))
      |-> (b_rdata == $past(a_wdata, 2)));

endmodule

// File: rtl/nlr_cog_port.sv
module nlr_cog_port #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_en,
   input  logic              req_we,
   input  logic              req_nbr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              own_en,
   output logic              nbr_en,
   output logic              acc_we,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_wdata,
   input  logic [DATA_W-1:0] own_rdata,
   input  logic [DATA_W-1:0] nbr_rdata,
   output logic [DATA_W-1:0] rdata
);

   logic sel_q;

   assign own_en    = req_en & ~req_nbr;
   assign nbr_en    = req_en & req_nbr;
   assign acc_we    = req_we;
   assign acc_addr  = req_addr;
   assign acc_wdata = req_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sel_q <= 1'b0;
      else if (req_en && !req_we) sel_q <= req_nbr;
   end

   assign rdata = sel_q ? nbr_rdata : own_rdata;

   // R8: lane holds through idle and write cycles
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_en && !req_we) |-> $stable(rdata));

endmodule

// File: rtl/nbr_lut_ring.sv
module nbr_lut_ring #(
   parameter int NUM_COGS = 16,
   parameter int ADDR_W   = 9,
   parameter int DATA_W   = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_COGS-1:0]          ctl_we,
   input  logic [NUM_COGS-1:0]          ctl_val,
   input  logic [NUM_COGS-1:0]          req_en,
   input  logic [NUM_COGS-1:0]          req_we,
   input  logic [NUM_COGS-1:0]          req_nbr,
   input  logic [NUM_COGS*ADDR_W-1:0]   req_addr,
   input  logic [NUM_COGS*DATA_W-1:0]   req_wdata,
   output logic [NUM_COGS*DATA_W-1:0]   rsp_rdata
);

   if (NUM_COGS < 2) begin : g_bad_cogs
      $error("nbr_lut_ring: NUM_COGS must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("nbr_lut_ring: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("nbr_lut_ring: DATA_W must be positive");
   end

   logic [NUM_COGS-1:0] share_q;
   logic [NUM_COGS-1:0] own_en, nbr_en, acc_we;
   logic [ADDR_W-1:0]   acc_addr  [NUM_COGS];
   logic [DATA_W-1:0]   acc_wdata [NUM_COGS];
   logic [DATA_W-1:0]   a_rd      [NUM_COGS];
   logic [DATA_W-1:0]   b_rd      [NUM_COGS];

   nlr_ctl #(.NUM_COGS(NUM_COGS)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_we  (ctl_we),
      .ctl_val (ctl_val),
      .share_q (share_q)
   );

   for (genvar c = 0; c < NUM_COGS; c++) begin : g_cog
      localparam int LO = nlr_pkg::lower_of(c, NUM_COGS);
      localparam int UP = nlr_pkg::upper_of(c, NUM_COGS);

      nlr_cog_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_en    (req_en[c]),
         .req_we    (req_we[c]),
         .req_nbr   (req_nbr[c]),
         .req_addr  (req_addr[c*ADDR_W +: ADDR_W]),
         .req_wdata (req_wdata[c*DATA_W +: DATA_W]),
         .own_en    (own_en[c]),
         .nbr_en    (nbr_en[c]),
         .acc_we    (acc_we[c]),
         .acc_addr  (acc_addr[c]),
         .acc_wdata (acc_wdata[c]),
         .own_rdata (a_rd[c]),
         .nbr_rdata (b_rd[LO]),
         .rdata     (rsp_rdata[c*DATA_W +: DATA_W])
      );

      nlr_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
         .clk     (clk),
         .rst_n   (rst_n),
         .a_en    (own_en[c]),
         .a_we    (acc_we[c]),
         .a_addr  (acc_addr[c]),
         .a_wdata (acc_wdata[c]),
         .a_rdata (a_rd[c]),
         .b_en    (nbr_en[UP]),
         .b_we    (acc_we[UP]),
         .b_addr  (acc_addr[UP]),
         .b_wdata (acc_wdata[UP]),
         .b_allow (share_q[c]),
         .b_rdata (b_rd[c])
      );
   end

endmodule

// File: tb/nbr_lut_ring_test.sv
module nbr_lut_ring_test;

   localparam int N  = 16;
   localparam int AW = 9;
   localparam int DW = 32;
   localparam int D  = 1 << AW;

   logic clk = 1'b0;
   logic rst_n;
   logic [N-1:0] ctl_we, ctl_val, req_en, req_we, req_nbr;
   logic [N*AW-1:0] req_addr;
   logic [N*DW-1:0] req_wdata;
   logic [N*DW-1:0] rsp_rdata;

   always #4 clk = ~clk;

   nbr_lut_ring #(.NUM_COGS(N), .ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_val(ctl_val),
      .req_en(req_en), .req_we(req_we), .req_nbr(req_nbr),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata)
   );

   bit [DW-1:0] mdl [N][D];
   bit          share [N];
   bit [DW-1:0] expd [N];
   bit          s_en [N], s_we [N], s_nbr [N], s_cwe [N], s_cval [N];
   int          s_addr [N];
   bit [DW-1:0] s_wd [N];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   function automatic bit [DW-1:0] lane(input int c);
      return rsp_rdata[c*DW +: DW];
   endfunction

   task automatic check(input string tag, input int c, input bit [DW-1:0] got, input bit [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s cog %0d got %h expected %h", tag, c, got, exp);
      end
   endtask

   task automatic clear_stim();
      for (int c = 0; c < N; c++) begin
         s_en[c] = 0; s_we[c] = 0; s_nbr[c] = 0; s_cwe[c] = 0; s_cval[c] = 0;
         s_addr[c] = 0; s_wd[c] = '0;
      end
   endtask

   task automatic drive();
      for (int c = 0; c < N; c++) begin
         req_en[c] = s_en[c]; req_we[c] = s_we[c]; req_nbr[c] = s_nbr[c];
         ctl_we[c] = s_cwe[c]; ctl_val[c] = s_cval[c];
         req_addr[c*AW +: AW]  = s_addr[c][AW-1:0];
         req_wdata[c*DW +: DW] = s_wd[c];
      end
   endtask

   // behavioural model of one clock edge
   task automatic model_edge();
      bit oww [N];
      for (int c = 0; c < N; c++) begin
         int lo = (c + N - 1) % N;
         if (s_en[c] && !s_we[c]) begin
            if (!s_nbr[c]) expd[c] = mdl[c][s_addr[c]];
            else           expd[c] = share[lo] ? mdl[lo][s_addr[c]] : '0;
         end
      end
      for (int r = 0; r < N; r++) begin
         int up = (r + 1) % N;
         oww[r] = s_en[r] && s_we[r] && !s_nbr[r];
         if (s_en[up] && s_we[up] && s_nbr[up] && share[r] &&
             !(oww[r] && s_addr[r] == s_addr[up]))
            mdl[r][s_addr[up]] = s_wd[up];
      end
      for (int r = 0; r < N; r++)
         if (oww[r]) mdl[r][s_addr[r]] = s_wd[r];
      for (int c = 0; c < N; c++)
         if (s_cwe[c]) share[c] = s_cval[c];
   endtask

   task automatic step(input string tag);
      drive();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      for (int c = 0; c < N; c++) check(tag, c, lane(c), expd[c]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired (all requirements) got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      clear_stim();
      for (int c = 0; c < N; c++) begin share[c] = 0; expd[c] = '0; end
      rst_n = 1'b0;
      drive();
      repeat (3) @(negedge clk);
      for (int c = 0; c < N; c++) check("R1 reset", c, lane(c), '0);
      rst_n = 1'b1;
      @(negedge clk);

      // clear every word through the owner ports (R8: lanes stay zero)
      for (int a = 0; a < D; a++) begin
         clear_stim();
         for (int c = 0; c < N; c++) begin s_en[c] = 1; s_we[c] = 1; s_addr[c] = a; end
         step("R8 write-hold");
      end

      // R1: share bits reset to 0, neighbour read gives zero
      clear_stim();
      s_en[3] = 1; s_nbr[3] = 1; s_addr[3] = 0;
      step("R1 share reset");

      // R9: enable sharing on all but core 5
      clear_stim();
      for (int c = 0; c < N; c++) begin s_cwe[c] = 1; s_cval[c] = (c != 5); end
      step("R9 load");

      // R2: own write then read
      clear_stim(); s_en[2] = 1; s_we[2] = 1; s_addr[2] = 10; s_wd[2] = 32'hA5A5_1234;
      step("R2");
      clear_stim(); s_en[2] = 1; s_addr[2] = 10;
      step("R2");
      check("R2 literal", 2, lane(2), 32'hA5A5_1234);

      // R3: core 3 reads core 2's RAM; core 3 writes into it, core 2 reads
      clear_stim(); s_en[3] = 1; s_nbr[3] = 1; s_addr[3] = 10;
      step("R3");
      check("R3 literal", 3, lane(3), 32'hA5A5_1234);
      clear_stim(); s_en[3] = 1; s_we[3] = 1; s_nbr[3] = 1; s_addr[3] = 11; s_wd[3] = 32'h0BAD_F00D;
      step("R3");
      clear_stim(); s_en[2] = 1; s_addr[2] = 11;
      step("R3");
      check("R3 literal", 2, lane(2), 32'h0BAD_F00D);

      // R4: wrap between last core and core 0
      clear_stim(); s_en[15] = 1; s_we[15] = 1; s_addr[15] = 20; s_wd[15] = 32'h1515_0000;
      s_en[0] = 1; s_we[0] = 1; s_nbr[0] = 1; s_addr[0] = 21; s_wd[0] = 32'h0000_0F0F;
      step("R4");
      clear_stim(); s_en[0] = 1; s_nbr[0] = 1; s_addr[0] = 20; s_en[15] = 1; s_addr[15] = 21;
      step("R4");
      check("R4 literal", 0, lane(0), 32'h1515_0000);
      check("R4 literal", 15, lane(15), 32'h0000_0F0F);

      // R5: collision, owner wins
      clear_stim(); s_en[6] = 1; s_we[6] = 1; s_addr[6] = 30; s_wd[6] = 32'h6666_0001;
      s_en[7] = 1; s_we[7] = 1; s_nbr[7] = 1; s_addr[7] = 30; s_wd[7] = 32'h7777_0002;
      step("R5");
      clear_stim(); s_en[6] = 1; s_addr[6] = 30;
      step("R5");
      check("R5 literal", 6, lane(6), 32'h6666_0001);

      // R6: read-before-write across ports
      clear_stim(); s_en[7] = 1; s_nbr[7] = 1; s_addr[7] = 30;
      s_en[6] = 1; s_we[6] = 1; s_addr[6] = 30; s_wd[6] = 32'h6666_0003;
      step("R6");
      check("R6 literal", 7, lane(7), 32'h6666_0001);
      clear_stim(); s_en[7] = 1; s_nbr[7] = 1; s_addr[7] = 30;
      step("R6");
      check("R6 literal", 7, lane(7), 32'h6666_0003);

      // R7: core 5 sharing disabled
      clear_stim(); s_en[5] = 1; s_we[5] = 1; s_addr[5] = 40; s_wd[5] = 32'h5555_AAAA;
      step("R7");
      clear_stim(); s_en[6] = 1; s_we[6] = 1; s_nbr[6] = 1; s_addr[6] = 40; s_wd[6] = 32'hDEAD_BEEF;
      step("R7");
      clear_stim(); s_en[6] = 1; s_nbr[6] = 1; s_addr[6] = 40; s_en[5] = 1; s_addr[5] = 40;
      step("R7");
      check("R7 literal", 6, lane(6), '0);
      check("R7 literal", 5, lane(5), 32'h5555_AAAA);

      // R9: clearing a share bit takes effect one cycle later
      clear_stim(); s_cwe[2] = 1; s_cval[2] = 0; s_en[3] = 1; s_nbr[3] = 1; s_addr[3] = 10;
      step("R9 same-cycle");
      check("R9 literal", 3, lane(3), 32'hA5A5_1234);
      clear_stim(); s_en[3] = 1; s_nbr[3] = 1; s_addr[3] = 10;
      step("R9 next-cycle");
      check("R9 literal", 3, lane(3), '0);

      // R8: idle cycles hold
      clear_stim();
      step("R8 idle");
      step("R8 idle");

      // R10: concurrent random traffic on a narrow address window
      for (int n = 0; n < 3000; n++) begin
         clear_stim();
         for (int c = 0; c < N; c++) begin
            s_en[c]   = ($urandom % 4) != 0;
            s_we[c]   = $urandom % 2;
            s_nbr[c]  = $urandom % 2;
            s_addr[c] = $urandom % 8;
            s_wd[c]   = $urandom;
            s_cwe[c]  = ($urandom % 16) == 0;
            s_cval[c] = ($urandom % 4) != 0;
         end
         step("R10");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule